// File: doc/BRIEF.md
# Oversampling Manchester Bit Decoder

This block turns a Manchester-coded serial line back into data bits. Its clock is a sample clock running at eight times the bit rate. The line is brought into the clock domain by a short synchronizer. Each bit period is then read as eight samples, split into two half-bit windows of four samples each. Each window's level is settled by a majority vote, so a single corrupted sample cannot change it. A high half followed by a low half yields a 0. A low half followed by a high half yields a 1. Two halves at the same level are reported as a coding error.

Bit timing is taken from the first line edge seen while idle, and that edge marks a bit boundary. Each later transition near mid-bit pulls the sample counter back into step, which absorbs a drift of one sample per bit. A small packer shifts valid bits into a byte with the first bit received in the most significant position. After sixteen edge-free samples the decoder drops back to idle and discards any partial byte.

Top module: `manchester_decoder`

## Requirements
- R1: A bit period of four low samples followed by four high samples decodes as bit_out=1. Four high samples followed by four low samples decodes as bit_out=0. The first edge seen while idle is taken as the start of a bit.
- R2: A half-bit window with exactly one sample of the opposite level still takes the majority level, and the bit decodes correctly.
- R3: A half-bit window with only two high samples out of four counts as low. A period of high, high, then six lows is therefore a coding error.
- R4: When both half-bit windows of a period resolve to the same level, bit_err pulses for one cycle and no bit_valid is produced for that period.
- R5: bit_valid is a one-cycle strobe, one per decoded bit. bit_out holds the decoded value in that cycle. bit_valid and bit_err are never high together.
- R6: A transition that lands one sample early or one sample late around mid-bit re-centres the sample counter. Bits of seven or nine samples therefore decode correctly, including several in a row.
- R7: The packer shifts valid bits in MSB first. It pulses byte_ready for one cycle, in the cycle after the eighth bit_valid. byte_out takes the assembled byte in that same cycle and holds it until the next byte_ready.
- R8: After sixteen consecutive samples with no line edge, the decoder returns to idle and clears the partial byte. The next byte is then assembled from bits received after that point only.
- R9: During and after reset, before any line activity, bit_valid, bit_err and byte_ready are 0 and byte_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, eight times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_in | input | 1 | Manchester-coded serial line, asynchronous to clk |
| bit_out | output | 1 | Decoded bit value, meaningful while bit_valid is high |
| bit_valid | output | 1 | One-cycle strobe for each decoded bit |
| bit_err | output | 1 | One-cycle strobe for a bit period with no mid-bit transition |
| byte_out | output | BYTE_W | Last assembled byte, first received bit in the MSB |
| byte_ready | output | 1 | One-cycle strobe when byte_out takes a new byte |

## Verification
The bench builds the decoder with its defaults: eight samples per bit, a vote threshold of three, a sixteen-sample idle limit and the byte packer enabled. The idle limit is only twice the bit length, so every frame ends with exactly one predictable trailing coding error followed by a timeout, and the idle clearing of a partial byte can be reached in a few dozen cycles. With four-sample halves, one flipped sample sits just inside the vote margin and two flipped samples sit just outside it. A one-sample shift sits at the edge of the re-centring window. Clean, glitched, stretched and shortened bit streams are therefore all reachable with short hand-built frames.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mdec_state_e;
endpackage

// File: rtl/mdec_rst_sync.sv
module mdec_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) chain_q <= 2'b00;
    else          chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_n_s = chain_q[1];
endmodule

// File: rtl/mdec_line_sync.sv
module mdec_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic smp,
  output logic edge_det
);
  logic [STAGES-1:0] flop_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) flop_q[g] <= 1'b0;
          else        flop_q[g] <= line_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) flop_q[g] <= 1'b0;
          else        flop_q[g] <= flop_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= flop_q[STAGES-1];
  end

  assign smp      = flop_q[STAGES-1];
  assign edge_det = flop_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/mdec_core.sv
module mdec_core
  import mdec_pkg::*;
#(
  parameter int OSR        = 8,
  parameter int VOTE       = 3,
  parameter int IDLE_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp,
  input  logic edge_det,
  output logic bit_valid,
  output logic bit_out,
  output logic bit_err,
  output logic idle_clr
);
  localparam int HALF = OSR / 2;
  localparam int CW   = $clog2(OSR);
  localparam int HW   = $clog2(HALF + 1);
  localparam int IW   = $clog2(IDLE_LIMIT);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);
  localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] HALF_V   = CW'(HALF);
  localparam logic [CW-1:0] MID_LO   = CW'(HALF - 1);
  localparam logic [CW-1:0] MID_HI   = CW'(HALF + 1);
  localparam logic [HW-1:0] VOTE_V   = HW'(VOTE);
  localparam logic [IW-1:0] IDLE_TOP = IW'(IDLE_LIMIT - 1);

  mdec_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [HW-1:0] h1_q, h1_d, h2_q, h2_d;
  logic [IW-1:0] idle_q, idle_d;
  logic          v_q, v_d, b_q, b_d, e_q, e_d, clr_q, clr_d;
  logic [HW-1:0] smp_w;
  logic          hi1, hi2;

  assign smp_w = {{(HW-1){1'b0}}, smp};

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    h1_d   = h1_q;
    h2_d   = h2_q;
    idle_d = idle_q;
    v_d    = 1'b0;
    b_d    = b_q;
    e_d    = 1'b0;
    clr_d  = 1'b0;
    hi1    = (h1_q >= VOTE_V);
    hi2    = ((h2_q + smp_w) >= VOTE_V);
    case (st_q)
      ST_IDLE: begin
        if (edge_det) begin
          st_d   = ST_RUN;
          cnt_d  = CNT_ONE;
          h1_d   = smp_w;
          h2_d   = '0;
          idle_d = '0;
        end
      end
      default: begin
        idle_d = edge_det ? '0 : idle_q + IW'(1);
        if (!edge_det && idle_q == IDLE_TOP) begin
          st_d   = ST_IDLE;
          clr_d  = 1'b1;
          cnt_d  = '0;
          h1_d   = '0;
          h2_d   = '0;
          idle_d = '0;
        end else if (edge_det && cnt_q >= MID_LO && cnt_q <= MID_HI) begin
          // mid-bit transition: this sample opens the second half
          h2_d  = smp_w;
          cnt_d = MID_HI;
        end else if (cnt_q == CNT_LAST) begin
          if (hi1 != hi2) begin
            v_d = 1'b1;
            b_d = hi2;
          end else begin
            e_d = 1'b1;
          end
          cnt_d = '0;
          h1_d  = '0;
          h2_d  = '0;
        end else if (cnt_q < HALF_V) begin
          h1_d  = h1_q + smp_w;
          cnt_d = cnt_q + CNT_ONE;
        end else begin
          h2_d  = h2_q + smp_w;
          cnt_d = cnt_q + CNT_ONE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      h1_q   <= '0;
      h2_q   <= '0;
      idle_q <= '0;
      v_q    <= 1'b0;
      b_q    <= 1'b0;
      e_q    <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      h1_q   <= h1_d;
      h2_q   <= h2_d;
      idle_q <= idle_d;
      v_q    <= v_d;
      b_q    <= b_d;
      e_q    <= e_d;
      clr_q  <= clr_d;
    end
  end

  assign bit_valid = v_q;
  assign bit_out   = b_q;
  assign bit_err   = e_q;
  assign idle_clr  = clr_q;
endmodule

// File: rtl/mdec_packer.sv
module mdec_packer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              clr,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_ready
);
  localparam int NW = $clog2(BYTE_W);
  localparam logic [NW-1:0] LAST = NW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q, sh_d, out_q, out_d;
  logic [NW-1:0]     n_q, n_d;
  logic              rdy_d, rdy_q;
  logic              en;

  assign en = bit_valid | clr;

  always_comb begin
    sh_d  = sh_q;
    n_d   = n_q;
    out_d = out_q;
    rdy_d = 1'b0;
    if (clr) begin
      sh_d = '0;
      n_d  = '0;
    end else if (bit_valid) begin
      sh_d = {sh_q[BYTE_W-2:0], bit_in};
      if (n_q == LAST) begin
        n_d   = '0;
        out_d = {sh_q[BYTE_W-2:0], bit_in};
        rdy_d = 1'b1;
      end else begin
        n_d = n_q + NW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      n_q   <= '0;
      out_q <= '0;
    end else if (en) begin
      sh_q  <= sh_d;
      n_q   <= n_d;
      out_q <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy_d;
  end

  assign byte_out   = out_q;
  assign byte_ready = rdy_q;
endmodule

// File: rtl/manchester_decoder.sv
module manchester_decoder #(
  parameter int OSR         = 8,
  parameter int VOTE        = 3,
  parameter int IDLE_LIMIT  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8,
  parameter bit PACK_EN     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  output logic              bit_out,
  output logic              bit_valid,
  output logic              bit_err,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_ready
);
  logic rst_n_s, smp, edge_det, idle_clr;

  mdec_rst_sync u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  mdec_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .line_in  (line_in),
    .smp      (smp),
    .edge_det (edge_det)
  );

  mdec_core #(.OSR(OSR), .VOTE(VOTE), .IDLE_LIMIT(IDLE_LIMIT)) u_core (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .smp       (smp),
    .edge_det  (edge_det),
    .bit_valid (bit_valid),
    .bit_out   (bit_out),
    .bit_err   (bit_err),
    .idle_clr  (idle_clr)
  );

  generate
    if (PACK_EN) begin : g_pack
      mdec_packer #(.BYTE_W(BYTE_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n_s),
        .bit_valid  (bit_valid),
        .bit_in     (bit_out),
        .clr        (idle_clr),
        .byte_out   (byte_out),
        .byte_ready (byte_ready)
      );
    end else begin : g_nopack
      assign byte_out   = '0;
      assign byte_ready = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/mdec_checker.sv
module mdec_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_valid,
  input logic              bit_err,
  input logic [BYTE_W-1:0] byte_out,
  input logic              byte_ready
);
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_valid && bit_err));

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  p_err_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |=> !bit_err);

  p_ready_after_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> $past(bit_valid));

  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |=> !byte_ready);

  p_byte_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_ready |-> $stable(byte_out));
endmodule

bind manchester_decoder mdec_checker #(.BYTE_W(BYTE_W)) u_mdec_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_valid  (bit_valid),
  .bit_err    (bit_err),
  .byte_out   (byte_out),
  .byte_ready (byte_ready)
);

// File: tb/test_manchester_decoder.sv
`timescale 1ns/1ps
module test_manchester_decoder;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_in;
  logic       bit_out, bit_valid, bit_err, byte_ready;
  logic [7:0] byte_out;

  int total = 0;
  int bad   = 0;

  // monitor state, written only by the monitor process
  logic [31:0] rx_bits = '0;
  int          rx_n = 0, er_n = 0, rd_n = 0;
  logic [7:0]  rx_byte = '0;

  always #5 clk = ~clk;

  manchester_decoder i_manchester_decoder (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (line_in),
    .bit_out    (bit_out),
    .bit_valid  (bit_valid),
    .bit_err    (bit_err),
    .byte_out   (byte_out),
    .byte_ready (byte_ready)
  );

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (bit_valid) begin
        rx_bits <= {rx_bits[30:0], bit_out};
        rx_n    <= rx_n + 1;
      end
      if (bit_err)    er_n <= er_n + 1;
      if (byte_ready) begin
        rd_n    <= rd_n + 1;
        rx_byte <= byte_out;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(input logic lv);
    @(negedge clk);
    line_in = lv;
  endtask

  task automatic send_bit(input logic b, input int mode);
    int n1;
    logic g;
    n1 = (mode == 2) ? 5 : (mode == 3) ? 3 : 4;
    g  = (mode == 1);
    for (int i = 0; i < n1; i++) put(~b ^ (g && i == 1));
    for (int i = 0; i < 4; i++)  put(b ^ (g && i == 2));
  endtask

  task automatic send_raw(input logic [7:0] pat);
    for (int i = 7; i >= 0; i--) put(pat[i]);
  endtask

  task automatic settle();
    repeat (30) put(line_in);
  endtask

  task automatic prep(input logic msb);
    if (line_in != msb) begin
      put(msb);
      settle();
    end
  endtask

  // table: {byte, mode} with mode 0 clean, 1 one glitch per half, 2 late, 3 early
  localparam logic [9:0] VEC [6] = '{
    {8'hA5, 2'd0}, {8'h00, 2'd0}, {8'hFF, 2'd1},
    {8'h3C, 2'd2}, {8'hC3, 2'd3}, {8'h5A, 2'd1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL R0 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    int b_n, b_e, b_r;
    logic [7:0] v;
    int m;
    string rq;
    rst_n   = 1'b0;
    line_in = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9", "bit_valid in reset", int'(bit_valid), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9", "bit_valid", int'(bit_valid), 0);
    chk("R9", "bit_err", int'(bit_err), 0);
    chk("R9", "byte_ready", int'(byte_ready), 0);
    chk("R9", "byte_out", int'(byte_out), 0);

    // vector table walk
    for (int k = 0; k < 6; k++) begin
      v  = VEC[k][9:2];
      m  = int'(VEC[k][1:0]);
      rq = (m == 1) ? "R2" : (m >= 2) ? "R6" : "R1";
      prep(v[7]);
      b_n = rx_n; b_e = er_n; b_r = rd_n;
      for (int i = 7; i >= 0; i--) send_bit(v[i], m);
      settle();
      chk("R5", "valid bit count", rx_n - b_n, 8);
      chk(rq, "decoded bits", int'(rx_bits[7:0]), int'(v));
      chk("R7", "byte_ready count", rd_n - b_r, 1);
      chk("R7", "byte_out", int'(rx_byte), int'(v));
      chk("R4", "trailing error count", er_n - b_e, 1);
    end

    // R4: flat period inside a frame
    v = 8'hF0;
    prep(1'b1);
    b_n = rx_n; b_e = er_n; b_r = rd_n;
    for (int i = 7; i >= 3; i--) send_bit(v[i], 0);
    send_raw(8'h00);
    for (int i = 2; i >= 0; i--) send_bit(v[i], 0);
    settle();
    chk("R4", "error count with flat period", er_n - b_e, 2);
    chk("R4", "valid count with flat period", rx_n - b_n, 8);
    chk("R4", "byte around flat period", int'(rx_byte), int'(v));

    // R3: half with two highs counts low
    prep(1'b1);
    b_n = rx_n; b_e = er_n; b_r = rd_n;
    for (int i = 7; i >= 3; i--) send_bit(v[i], 0);
    send_raw(8'b1100_0000);
    for (int i = 2; i >= 0; i--) send_bit(v[i], 0);
    settle();
    chk("R3", "error count two-of-four", er_n - b_e, 2);
    chk("R3", "valid count two-of-four", rx_n - b_n, 8);
    chk("R3", "byte around two-of-four", int'(rx_byte), int'(v));

    // R8: partial byte discarded on idle
    prep(1'b1);
    b_r = rd_n;
    send_bit(1'b1, 0); send_bit(1'b0, 0); send_bit(1'b1, 0);
    send_bit(1'b1, 0); send_bit(1'b0, 0);
    settle();
    chk("R8", "no byte from partial", rd_n - b_r, 0);
    v = 8'h96;
    prep(v[7]);
    b_r = rd_n;
    for (int i = 7; i >= 0; i--) send_bit(v[i], 0);
    settle();
    chk("R8", "byte_ready after idle", rd_n - b_r, 1);
    chk("R8", "byte after idle clear", int'(rx_byte), int'(v));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule